// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block takes the single-bit output of an analog comparator, brings it into the local clock domain through a flop synchronizer and watches it for transitions. A two-bit mode field picks which transition counts as an event: any change, a falling edge only, or a rising edge only. The fourth code is reserved and raises no events. Each event sets a sticky flag. The interrupt request is the flag gated by a local enable bit and by the processor's global interrupt enable.

Software clears the flag by writing a one to its bit. The flag also clears on its own when the interrupt controller acknowledges the vector. A separate control bit routes the synchronized comparator level onto a capture-trigger output for a timer. When that bit is low, the capture trigger stays inactive.

All control is held in one register, which is written through a write strobe and read back through a read bus. The flag sets whatever the enable bits hold, so software can poll the flag with interrupts disabled. Software must clear the local enable before it changes the mode.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset, the register reads back as zero, and `irq_o` and `cap_trig_o` are 0.
- R2: With mode 2'b00 (register bits [1:0]), both a rising and a falling transition of the comparator set the flag (register bit 4).
- R3: With mode 2'b10, a falling transition sets the flag and a rising transition leaves it clear.
- R4: With mode 2'b11, a rising transition sets the flag and a falling transition leaves it clear.
- R5: With the reserved mode 2'b01, no comparator transition ever sets the flag.
- R6: `irq_o` is 1 exactly while the flag, the local enable (register bit 3) and `gie_i` are all 1.
- R7: A write with bit 4 set clears the flag. A write with bit 4 clear leaves the flag unchanged.
- R8: A one-cycle pulse on `irq_ack_i` clears the flag.
- R9: If an event and a clear (a write of one or an acknowledge) fall in the same cycle, the flag stays set.
- R10: When the capture enable (register bit 2) is 1, `cap_trig_o` follows the synchronized comparator level (register bit 5, read-only). When the capture enable is 0, `cap_trig_o` is 0.
- R11: The flag sets on an event even when the local enable and `gie_i` are both 0.
- R12: A comparator change that is driven between clock edges sets the flag at the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_i | input | 1 | Asynchronous comparator output |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | REG_W | Register write data |
| rd_data_o | output | REG_W | Register read data |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt vector acknowledge |
| irq_o | output | 1 | Interrupt request |
| cap_trig_o | output | 1 | Timer capture trigger |

## Verification
The bench tests both edge polarities in each mode. A design that decodes the mode wrong shows up as a flag that sets on the opposite edge, or a flag that sets in the reserved mode. It drives an event into the same cycle as an acknowledge, which catches a design that lets the clear win and loses the interrupt. It writes a zero to the flag bit and then a one, which separates a true write-one-to-clear bit from a plainly written bit. It also counts edges from the input change to the flag. A synchronizer that is one stage short or one stage long moves the flag by a cycle and is caught there.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
   typedef enum logic [1:0] {
      MODE_ANY  = 2'b00,
      MODE_RSV  = 2'b01,
      MODE_FALL = 2'b10,
      MODE_RISE = 2'b11
   } cmp_mode_e;

   localparam int FLD_CAP  = 2;
   localparam int FLD_IE   = 3;
   localparam int FLD_FLAG = 4;
   localparam int FLD_LVL  = 5;
   localparam int FLD_MIN_W = FLD_LVL + 1;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cmp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else if (s == 0) chain_q[s] <= d_i;
         else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
   import cmp_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl_i,
   input  cmp_mode_e mode_i,
   output logic      evt_o
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;

   always_comb begin
      unique case (mode_i)
         MODE_ANY:  evt_o = rise | fall;
         MODE_FALL: evt_o = fall;
         MODE_RISE: evt_o = rise;
         default:   evt_o = 1'b0;
      endcase
   end

   AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_RSV) |-> !evt_o);  // R5
   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> (lvl_i != prev_q));  // R2
endmodule

// File: rtl/cmp_flag_ctrl.sv
module cmp_flag_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic w1c_i,
   input  logic ack_i,
   input  logic ie_i,
   input  logic gie_i,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag_q <= 1'b0;
      else if (evt_i)          flag_q <= 1'b1;
      else if (w1c_i || ack_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & ie_i & gie_i;

   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_q);  // R9
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !evt_i) |=> !flag_q);  // R8
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_i && !evt_i) |=> !flag_q);  // R7
   AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(evt_i));  // R11
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
   import cmp_irq_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_i,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   input  logic             gie_i,
   input  logic             irq_ack_i,
   output logic             irq_o,
   output logic             cap_trig_o
);
   if (REG_W < FLD_MIN_W) begin : g_bad_width
      $error("cmp_irq_ctrl: REG_W too small for the field layout");
   end

   cmp_mode_e mode_q;
   logic      cap_q, ie_q;
   logic      lvl, evt, flag, w1c;
   logic      unused_wr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_ANY;
         cap_q  <= 1'b0;
         ie_q   <= 1'b0;
      end else if (wr_en_i) begin
         mode_q <= cmp_mode_e'(wr_data_i[1:0]);
         cap_q  <= wr_data_i[FLD_CAP];
         ie_q   <= wr_data_i[FLD_IE];
      end
   end

   assign w1c            = wr_en_i & wr_data_i[FLD_FLAG];
   assign unused_wr_bits = ^wr_data_i[REG_W-1:FLD_LVL];

   cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(lvl)
   );

   cmp_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .mode_i(mode_q), .evt_o(evt)
   );

   cmp_flag_ctrl u_flag (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .w1c_i(w1c), .ack_i(irq_ack_i),
      .ie_i(ie_q), .gie_i(gie_i), .flag_o(flag), .irq_o(irq_o)
   );

   always_comb begin
      rd_data_o           = '0;
      rd_data_o[1:0]      = mode_q;
      rd_data_o[FLD_CAP]  = cap_q;
      rd_data_o[FLD_IE]   = ie_q;
      rd_data_o[FLD_FLAG] = flag;
      rd_data_o[FLD_LVL]  = lvl;
   end

   assign cap_trig_o = cap_q & lvl;

   AST_CAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_q |-> !cap_trig_o);  // R10
   AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (gie_i && rd_data_o[FLD_FLAG]));  // R6
endmodule

// File: tb/cmp_irq_ctrl_tb.sv
module cmp_irq_ctrl_tb_top;
   localparam int W = 8;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cmp = 1'b0, wr_en = 1'b0, gie = 1'b0, ack = 1'b0;
   logic [W-1:0] wr_data = '0, rd_data;
   logic irq, cap_trig;
   int n_vec = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   cmp_irq_ctrl #(.REG_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .rd_data_o(rd_data), .gie_i(gie),
      .irq_ack_i(ack), .irq_o(irq), .cap_trig_o(cap_trig)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // fields: mode[1:0], cap bit2, ie bit3, flag bit4 (W1C)
   task automatic wr(input logic [1:0] mode, input logic cap, input logic ie, input logic w1c);
      wr_data = {3'b000, w1c, ie, cap, mode};
      wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic drive_cmp(input logic v);
      cmp = v;
      tick(4);
   endtask

   task automatic t_reset;
      chk("R1 reg", rd_data, '0);
      chk("R1 irq", {7'd0, irq}, 8'd0);
      chk("R1 cap", {7'd0, cap_trig}, 8'd0);
   endtask

   task automatic t_modes;
      wr(2'b00, 0, 0, 1);
      drive_cmp(1); chk("R2 rise", {7'd0, rd_data[4]}, 8'd1);
      wr(2'b00, 0, 0, 1);
      drive_cmp(0); chk("R2 fall", {7'd0, rd_data[4]}, 8'd1);
      wr(2'b10, 0, 0, 1);
      drive_cmp(1); chk("R3 rise ignored", {7'd0, rd_data[4]}, 8'd0);
      drive_cmp(0); chk("R3 fall", {7'd0, rd_data[4]}, 8'd1);
      wr(2'b11, 0, 0, 1);
      drive_cmp(1); chk("R4 rise", {7'd0, rd_data[4]}, 8'd1);
      wr(2'b11, 0, 0, 1);
      drive_cmp(0); chk("R4 fall ignored", {7'd0, rd_data[4]}, 8'd0);
      wr(2'b01, 0, 0, 1);
      drive_cmp(1); drive_cmp(0);
      chk("R5 reserved", {7'd0, rd_data[4]}, 8'd0);
   endtask

   task automatic t_irq_gate;
      wr(2'b00, 0, 0, 1);
      drive_cmp(1);
      chk("R11 flag with enables off", {7'd0, rd_data[4]}, 8'd1);
      chk("R6 ie0 gie0", {7'd0, irq}, 8'd0);
      gie = 1'b1; tick(1);
      chk("R6 ie0 gie1", {7'd0, irq}, 8'd0);
      wr(2'b00, 0, 1, 0);
      chk("R6 ie1 gie1", {7'd0, irq}, 8'd1);
      gie = 1'b0; tick(1);
      chk("R6 ie1 gie0", {7'd0, irq}, 8'd0);
      gie = 1'b1;
   endtask

   task automatic t_clear;
      wr(2'b00, 0, 1, 0);
      chk("R7 write zero keeps", {7'd0, rd_data[4]}, 8'd1);
      wr(2'b00, 0, 1, 1);
      chk("R7 write one clears", {7'd0, rd_data[4]}, 8'd0);
      chk("R6 irq drops", {7'd0, irq}, 8'd0);
      drive_cmp(0);
      ack = 1'b1; tick(1); ack = 1'b0;
      chk("R8 ack clears", {7'd0, rd_data[4]}, 8'd0);
   endtask

   task automatic t_race;
      drive_cmp(1);
      cmp = 1'b0;
      tick(2);
      ack = 1'b1; tick(1); ack = 1'b0;
      chk("R9 event beats ack", {7'd0, rd_data[4]}, 8'd1);
      cmp = 1'b1;
      tick(2);
      wr(2'b00, 0, 1, 1);
      chk("R9 event beats w1c", {7'd0, rd_data[4]}, 8'd1);
   endtask

   task automatic t_latency;
      wr(2'b00, 0, 0, 1);
      cmp = 1'b0;
      tick(2);
      chk("R12 not at edge 2", {7'd0, rd_data[4]}, 8'd0);
      tick(1);
      chk("R12 set at edge 3", {7'd0, rd_data[4]}, 8'd1);
   endtask

   task automatic t_capture;
      wr(2'b00, 0, 0, 1);
      drive_cmp(1);
      chk("R10 cap off", {7'd0, cap_trig}, 8'd0);
      wr(2'b00, 1, 0, 1);
      chk("R10 cap on high", {7'd0, cap_trig}, 8'd1);
      chk("R10 level bit", {7'd0, rd_data[5]}, 8'd1);
      drive_cmp(0);
      chk("R10 cap on low", {7'd0, cap_trig}, 8'd0);
   endtask

   initial begin : watchdog
      #200000;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_modes();
      t_irq_gate();
      t_clear();
      t_race();
      t_latency();
      t_capture();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule